// File: doc/BRIEF.md
# Supply-Drop Interrupt Generator

This block turns the one-bit output of an external supply comparator into a supply-drop interrupt. The comparator reads 1 while the supply is above its threshold. Its output first passes through a two-flop synchronizer. A digital filter then samples it on a slow tick taken from a free-running divider. The divider never stops, so the filter keeps working while the core sleeps in its low-power wait mode.

A falling edge of the selected level sets a sticky drop flag. The selected level is the filter output, or the synchronized input when the filter is bypassed. Only software clears the flag. While the flag is set, no further drop request can be raised. The drop request lasts one clock cycle and is merged with the watchdog and oscillator-fault requests onto one non-maskable interrupt line.

Software drives five controls: detector enable, interrupt enable, filter enable, a two-bit rate select, and a one-cycle flag clear.

Top module: `supply_drop_irq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `drop_flag_o` and `drop_irq_o` are 0. `nmi_o` still follows `wdt_irq_i | osc_irq_i`.
- R2: `sense_ok_i` reaches the flag logic through exactly two register stages. With the filter bypassed, a drop driven just after edge k sets `drop_flag_o` at edge k+3.
- R3: The sampling tick comes from a counter that starts at 0 on reset and is never gated. With select value s, the filter samples at every edge where the count since reset, modulo 16·2^s, equals 16·2^s − 1. Select 0 gives 16 cycles, 1 gives 32, 2 gives 64 and 3 gives 128.
- R4: The filter output resets to 1. It changes only after two consecutive ticks sample the same new value, so a dip seen by a single tick is rejected.
- R5: When `filt_en_i` is 0, the synchronized (and enable-forced) level feeds the flag logic directly.
- R6: A 1-to-0 transition of the selected level sets `drop_flag_o`. The flag then stays 1 until a clear or a detector disable.
- R7: If `flag_clr_i` is 1 in the same cycle as a falling edge, the clear wins. The flag stays 0 and no request is raised.
- R8: When `det_en_i` is 0, the detection level is forced to 1 and the flag is cleared on the next edge.
- R9: `drop_irq_o` pulses for one cycle, in the cycle the flag first reads 1, and only if `irq_en_i` was 1 at that edge.
- R10: No `drop_irq_o` pulse occurs while `drop_flag_o` is already 1.
- R11: `nmi_o` is the OR of `drop_irq_o`, `wdt_irq_i` and `osc_irq_i`, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, also used by the filter divider |
| rst | input | 1 | Synchronous active-high reset |
| sense_ok_i | input | 1 | Raw comparator output, 1 = supply above threshold |
| det_en_i | input | 1 | Detector enable |
| irq_en_i | input | 1 | Drop-interrupt enable |
| filt_en_i | input | 1 | 1 = use the digital filter, 0 = bypass it |
| rate_sel_i | input | 2 | Filter sampling-rate select |
| flag_clr_i | input | 1 | One-cycle software clear of the drop flag |
| wdt_irq_i | input | 1 | Watchdog interrupt request |
| osc_irq_i | input | 1 | Oscillation stop/restart interrupt request |
| drop_flag_o | output | 1 | Sticky supply-drop flag |
| drop_irq_o | output | 1 | One-cycle supply-drop request |
| nmi_o | output | 1 | Merged non-maskable interrupt |

## Verification
The bench builds the block with its default parameters: a prescale of 8, four rate taps and a two-flop synchronizer. With these values the slowest sampling window is 128 cycles. Held input levels of up to 300 cycles therefore drive the filter through every state, at every rate, both as rejected single-tick dips and as accepted drops. The same defaults make the exact three-edge bypass latency and the tick phase counted from reset observable at the pins.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
    // Filter states: stable high, one low sample seen, stable low, one high sample seen
    typedef enum logic [1:0] {
        FS_OK       = 2'd0,
        FS_OK_DIP   = 2'd1,
        FS_LOW      = 2'd2,
        FS_LOW_RISE = 2'd3
    } filt_state_t;

    // Drop flag states
    typedef enum logic {
        FG_CLEAR = 1'b0,
        FG_DROP  = 1'b1
    } flag_state_t;
endpackage

// File: rtl/sdi_sync.sv
module sdi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    // Resets to 1 (supply OK) so no false drop appears after reset
    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[STAGES-2:0], d_i};
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/sdi_tick_gen.sv
module sdi_tick_gen #(
    parameter int PRE_DIV = 8,  // power of two
    parameter int N_RATES = 4   // power of two
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(N_RATES)-1:0] sel_i,
    output logic                       tick_o
);
    localparam int PRE_W = $clog2(PRE_DIV);
    localparam int CW    = PRE_W + N_RATES;

    logic [CW-1:0]      cnt_q;
    logic [N_RATES-1:0] tap;

    // Free-running: no gating input, so it runs through wait mode
    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    // Tap r fires once every PRE_DIV * 2^(r+1) cycles
    for (genvar r = 0; r < N_RATES; r++) begin : g_tap
        assign tap[r] = &cnt_q[PRE_W+r:0];
    end

    assign tick_o = tap[sel_i];
endmodule

// File: rtl/sdi_filter.sv
module sdi_filter
    import sdi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic din_i,
    output logic filt_o
);
    filt_state_t st_q, st_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= FS_OK;
        else     st_q <= st_d;
    end

    // Transitions: OK->OK_DIP (low sample), OK_DIP->LOW (second low),
    // OK_DIP->OK (high), LOW->LOW_RISE (high), LOW_RISE->OK (second high),
    // LOW_RISE->LOW (low). Moves only on a tick.
    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            unique case (st_q)
                FS_OK:       if (!din_i) st_d = FS_OK_DIP;
                FS_OK_DIP:   st_d = din_i ? FS_OK : FS_LOW;
                FS_LOW:      if (din_i) st_d = FS_LOW_RISE;
                FS_LOW_RISE: st_d = din_i ? FS_OK : FS_LOW;
                default:     st_d = FS_OK;
            endcase
        end
    end

    // Outputs
    always_comb begin
        filt_o = 1'b1;
        unique case (st_q)
            FS_OK, FS_OK_DIP:   filt_o = 1'b1;
            FS_LOW, FS_LOW_RISE: filt_o = 1'b0;
            default:            filt_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/sdi_flag_ctl.sv
module sdi_flag_ctl
    import sdi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    input  logic det_en_i,
    input  logic irq_en_i,
    input  logic clr_i,
    output logic flag_o,
    output logic irq_o
);
    flag_state_t st_q, st_d;
    logic        lvl_q;
    logic        fall;
    logic        set_go;
    logic        irq_q;

    assign fall = lvl_q & ~level_i;

    // State register and previous-level register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= FG_CLEAR;
            lvl_q <= 1'b1;
        end else begin
            st_q  <= st_d;
            lvl_q <= level_i;
        end
    end

    // Transitions: T_SET CLEAR->DROP on a fall (no clear, detector on);
    // T_CLR DROP->CLEAR on a clear or detector disable.
    always_comb begin
        st_d   = st_q;
        set_go = 1'b0;
        unique case (st_q)
            FG_CLEAR: begin
                if (fall && !clr_i && det_en_i) begin
                    st_d   = FG_DROP;
                    set_go = 1'b1;
                end
            end
            FG_DROP: begin
                if (clr_i || !det_en_i) st_d = FG_CLEAR;
            end
            default: st_d = FG_CLEAR;
        endcase
    end

    // Outputs: flag from state, request registered with the set
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= set_go & irq_en_i;
    end

    always_comb begin
        flag_o = 1'b0;
        unique case (st_q)
            FG_CLEAR: flag_o = 1'b0;
            FG_DROP:  flag_o = 1'b1;
            default:  flag_o = 1'b0;
        endcase
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/supply_drop_irq.sv
module supply_drop_irq #(
    parameter int PRE_DIV     = 8,
    parameter int N_RATES     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sense_ok_i,
    input  logic                       det_en_i,
    input  logic                       irq_en_i,
    input  logic                       filt_en_i,
    input  logic [$clog2(N_RATES)-1:0] rate_sel_i,
    input  logic                       flag_clr_i,
    input  logic                       wdt_irq_i,
    input  logic                       osc_irq_i,
    output logic                       drop_flag_o,
    output logic                       drop_irq_o,
    output logic                       nmi_o
);
    logic sync_lvl;
    logic det_lvl;
    logic tick;
    logic filt_lvl;
    logic sel_lvl;

    sdi_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sense_ok_i),
        .q_o (sync_lvl)
    );

    // A disabled detector reads as "supply OK"
    assign det_lvl = det_en_i ? sync_lvl : 1'b1;

    sdi_tick_gen #(.PRE_DIV(PRE_DIV), .N_RATES(N_RATES)) i_tick (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (rate_sel_i),
        .tick_o (tick)
    );

    sdi_filter i_filt (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .din_i  (det_lvl),
        .filt_o (filt_lvl)
    );

    assign sel_lvl = filt_en_i ? filt_lvl : det_lvl;

    sdi_flag_ctl i_flag (
        .clk      (clk),
        .rst      (rst),
        .level_i  (sel_lvl),
        .det_en_i (det_en_i),
        .irq_en_i (irq_en_i),
        .clr_i    (flag_clr_i),
        .flag_o   (drop_flag_o),
        .irq_o    (drop_irq_o)
    );

    assign nmi_o = drop_irq_o | wdt_irq_i | osc_irq_i;
endmodule

// File: rtl/sdi_checker.sv
module sdi_checker (
    input logic clk,
    input logic rst,
    input logic det_en_i,
    input logic irq_en_i,
    input logic flag_clr_i,
    input logic drop_flag_o,
    input logic drop_irq_o,
    input logic nmi_o
);
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (drop_flag_o && det_en_i && !flag_clr_i) |=> drop_flag_o);

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
        flag_clr_i |=> !drop_flag_o);

    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (rst)
        !det_en_i |=> !drop_flag_o);

    assert_irq_with_flag_R9: assert property (@(posedge clk) disable iff (rst)
        drop_irq_o |-> drop_flag_o);

    assert_irq_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        drop_irq_o |=> !drop_irq_o);

    assert_irq_enabled_R9: assert property (@(posedge clk) disable iff (rst)
        drop_irq_o |-> $past(irq_en_i));

    assert_no_irq_flagged_R10: assert property (@(posedge clk) disable iff (rst)
        drop_flag_o |=> !drop_irq_o);

    assert_nmi_carries_R11: assert property (@(posedge clk) disable iff (rst)
        drop_irq_o |-> nmi_o);
endmodule

bind supply_drop_irq sdi_checker i_chk (
    .clk         (clk),
    .rst         (rst),
    .det_en_i    (det_en_i),
    .irq_en_i    (irq_en_i),
    .flag_clr_i  (flag_clr_i),
    .drop_flag_o (drop_flag_o),
    .drop_irq_o  (drop_irq_o),
    .nmi_o       (nmi_o)
);

// File: tb/test_supply_drop_irq.sv
module test_supply_drop_irq;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sense_ok_i = 1'b1;
    logic       det_en_i = 1'b1;
    logic       irq_en_i = 1'b1;
    logic       filt_en_i = 1'b0;
    logic [1:0] rate_sel_i = 2'd0;
    logic       flag_clr_i = 1'b0;
    logic       wdt_irq_i = 1'b0;
    logic       osc_irq_i = 1'b0;
    logic       drop_flag_o, drop_irq_o, nmi_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    supply_drop_irq i_supply_drop_irq (
        .clk(clk), .rst(rst), .sense_ok_i(sense_ok_i), .det_en_i(det_en_i),
        .irq_en_i(irq_en_i), .filt_en_i(filt_en_i), .rate_sel_i(rate_sel_i),
        .flag_clr_i(flag_clr_i), .wdt_irq_i(wdt_irq_i), .osc_irq_i(osc_irq_i),
        .drop_flag_o(drop_flag_o), .drop_irq_o(drop_irq_o), .nmi_o(nmi_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", what, act, exp, $time);
        end
    endtask

    // ---------------- reference model, built from the requirements ----------------
    bit m_s1, m_s2, m_lvlq, m_flag, m_irq;
    int m_cnt;
    int m_fst; // 0 ok, 1 ok+dip, 2 low, 3 low+rise

    function automatic int period_of(input logic [1:0] s);
        return 16 << s;
    endfunction

    function automatic int next_fst(input int f, input bit d);
        case (f)
            0: return d ? 0 : 1;
            1: return d ? 0 : 2;
            2: return d ? 3 : 2;
            default: return d ? 0 : 2;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 1; m_s2 = 1; m_lvlq = 1; m_flag = 0; m_irq = 0; m_cnt = 0; m_fst = 0;
        end else begin
            bit det, lvl, fall, tick;
            det  = det_en_i ? m_s2 : 1'b1;
            tick = ((m_cnt % period_of(rate_sel_i)) == period_of(rate_sel_i) - 1);
            lvl  = filt_en_i ? (m_fst < 2) : det;
            fall = m_lvlq && !lvl;
            m_irq = !m_flag && fall && !flag_clr_i && det_en_i && irq_en_i;
            if (flag_clr_i || !det_en_i) m_flag = 0;
            else if (fall)               m_flag = 1;
            if (tick) m_fst = next_fst(m_fst, det);
            m_cnt  = (m_cnt + 1) % 128;
            m_lvlq = lvl;
            m_s2 = m_s1;
            m_s1 = sense_ok_i;
        end
    end

    // per-cycle comparison away from the clock edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(drop_flag_o == m_flag, "R3 R4 R6 flag vs model", drop_flag_o, m_flag);
            chk(drop_irq_o == m_irq, "R9 R10 irq vs model", drop_irq_o, m_irq);
            chk(nmi_o == (m_irq | wdt_irq_i | osc_irq_i), "R11 nmi vs model",
                nmi_o, m_irq | wdt_irq_i | osc_irq_i);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WDOG_LIMIT);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        bit seen;
        void'($urandom(32'd2024));
        // R1: reset state
        step(3);
        chk(drop_flag_o == 0, "R1 flag in reset", drop_flag_o, 0);
        chk(drop_irq_o == 0, "R1 irq in reset", drop_irq_o, 0);
        chk(nmi_o == 0, "R1 nmi in reset", nmi_o, 0);
        wdt_irq_i = 1; #1;
        chk(nmi_o == 1, "R11 watchdog to nmi", nmi_o, 1);
        wdt_irq_i = 0; osc_irq_i = 1; #1;
        chk(nmi_o == 1, "R11 osc fault to nmi", nmi_o, 1);
        osc_irq_i = 0;
        rst = 0;
        step(1);
        chk(drop_flag_o == 0 && drop_irq_o == 0, "R1 first cycle after reset", drop_flag_o, 0);
        step(3);

        // R2 R5 R9: bypass latency and pulse
        sense_ok_i = 0;
        step(2);
        chk(drop_flag_o == 0, "R2 flag not before third edge", drop_flag_o, 0);
        step(1);
        chk(drop_flag_o == 1, "R2 R5 flag at third edge", drop_flag_o, 1);
        chk(drop_irq_o == 1, "R9 irq with flag set", drop_irq_o, 1);
        step(1);
        chk(drop_irq_o == 0, "R9 irq lasts one cycle", drop_irq_o, 0);

        // R6 R10: sticky flag, no second request
        sense_ok_i = 1; step(5);
        chk(drop_flag_o == 1, "R6 flag holds after recovery", drop_flag_o, 1);
        sense_ok_i = 0; seen = 0;
        for (int i = 0; i < 6; i++) begin step(1); if (drop_irq_o) seen = 1; end
        chk(!seen, "R10 no irq while flag set", seen, 0);

        // R6 clear
        flag_clr_i = 1; step(1); flag_clr_i = 0;
        chk(drop_flag_o == 0, "R6 software clear", drop_flag_o, 0);

        // R7: clear in the same cycle as the fall
        sense_ok_i = 1; step(4);
        sense_ok_i = 0; step(2);
        flag_clr_i = 1; step(1); flag_clr_i = 0;
        chk(drop_flag_o == 0 && drop_irq_o == 0, "R7 clear beats set", drop_flag_o, 0);
        step(3);
        chk(drop_flag_o == 0, "R7 no late set", drop_flag_o, 0);

        // R9: interrupt disabled
        irq_en_i = 0; sense_ok_i = 1; step(4);
        sense_ok_i = 0; seen = 0;
        for (int i = 0; i < 5; i++) begin step(1); if (drop_irq_o) seen = 1; end
        chk(!seen, "R9 no irq when disabled", seen, 0);
        chk(drop_flag_o == 1, "R9 flag still set when irq disabled", drop_flag_o, 1);
        irq_en_i = 1;

        // R8: detector disable clears and forces high
        det_en_i = 0; step(1);
        chk(drop_flag_o == 0, "R8 disable clears flag", drop_flag_o, 0);
        step(20);
        chk(drop_flag_o == 0, "R8 low input ignored while disabled", drop_flag_o, 0);
        det_en_i = 1; step(1);
        chk(drop_flag_o == 1, "R8 forced-high level falls on enable", drop_flag_o, 1);
        flag_clr_i = 1; step(1); flag_clr_i = 0;

        // R4: filter rejects a short dip, accepts a long drop
        filt_en_i = 1; rate_sel_i = 0; sense_ok_i = 1; step(300);
        flag_clr_i = 1; step(1); flag_clr_i = 0;
        sense_ok_i = 0; step(8); sense_ok_i = 1; step(100);
        chk(drop_flag_o == 0, "R4 single-tick dip rejected", drop_flag_o, 0);
        sense_ok_i = 0; step(40);
        chk(drop_flag_o == 1, "R4 held drop accepted", drop_flag_o, 1);

        // R3: slowest rate rejects a 100-cycle drop
        sense_ok_i = 1; rate_sel_i = 3; step(400);
        flag_clr_i = 1; step(1); flag_clr_i = 0;
        sense_ok_i = 0; step(100); sense_ok_i = 1; step(300);
        chk(drop_flag_o == 0, "R3 slow rate rejects 100-cycle drop", drop_flag_o, 0);

        // constrained random segments
        for (int seg = 0; seg < 220; seg++) begin
            int hold;
            det_en_i   = ($urandom % 10) != 0;
            irq_en_i   = ($urandom % 4) != 0;
            filt_en_i  = ($urandom % 3) != 0;
            rate_sel_i = 2'($urandom % 4);
            sense_ok_i = ($urandom % 2) != 0;
            wdt_irq_i  = ($urandom % 12) == 0;
            osc_irq_i  = ($urandom % 12) == 0;
            hold = 1 + ($urandom % 300);
            for (int c = 0; c < hold; c++) begin
                flag_clr_i = ($urandom % 60) == 0;
                step(1);
            end
            flag_clr_i = 0;
        end

        step(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule